// File: doc/BRIEF.md
# SPI Host Transfer Engine

This block is the serial core of an SPI host. Software, or a register front end, writes one control word that holds the clock mode, the bit order, the chip-select choice and a start bit. Two byte counts come with it: the total number of bytes to clock, and how many of those bytes come from a transmit FIFO. The engine pulls bytes from the FIFO and shifts them out on MOSI. When the transmit count runs out before the total count, it sends zero bytes instead. It samples MISO on the edge that the phase setting picks and hands each finished received byte to a receive FIFO, unless the control word says to drop received data. It raises a one-cycle completion pulse when the last byte has been clocked.

The serial clock moves only on a one-cycle enable pulse that an outside divider supplies, two pulses per SCLK period. The FIFOs sit outside the block too. If the transmit FIFO is empty while bytes are still owed, the engine waits with SCLK at its idle level. Chip selects are driven by the engine around each burst in automatic mode, or set by the control word in manual mode. One polarity bit sets the level of every chip select that is not asserted.

Top module: `spi_xfer_engine`

## Requirements
- R1: Control word bits: 0 enable, 1 host mode, 2 clock phase, 3 clock polarity, 4 chip select active low, 6 LSB first, 10 start, 13:12 chip-select index, 15 drop received bytes, 16 manual chip select, 17 manual level. After reset the control word reads zero. A write in idle stores the word. Bit 10 is kept, and a burst starts, only when bits 0 and 1 are also set in that write; otherwise bit 10 is stored as 0.
- R2: A started burst clocks exactly the burst count of 8-bit bytes, which is 16 SCLK edges per byte, and then gives one cycle of `xfer_done` after the last edge. A burst count of zero gives `xfer_done` with no SCLK edge.
- R3: The first min(transmit count, burst count) bytes are each taken from the transmit FIFO through a one-cycle `tx_pop`. Every later byte of the burst is sent as 0x00 and pops nothing.
- R4: SCLK rests at the polarity bit. With phase 0, MISO is sampled on the first edge of each bit period and MOSI changes on the second edge. With phase 1, MOSI changes on the first edge and MISO is sampled on the second.
- R5: With bit 6 clear, bytes are sent and received MSB first. With bit 6 set, they are sent and received LSB first.
- R6: While bit 15 is set, `rx_push` never rises. Otherwise there is one push per byte, which carries the byte just received.
- R7: While bytes are owed from the FIFO and `tx_valid` is low, the engine makes no SCLK edge and no pop. It resumes once data arrives.
- R8: SCLK changes level only in a cycle that follows a high `sclk_en`.
- R9: In automatic mode, the chip select named by bits 13:12 is asserted from the cycle after the start until the last SCLK edge of the burst. It is released in the `xfer_done` cycle.
- R10: In manual mode (bit 16), the selected chip-select pin takes the value of bit 17 directly, whether or not a burst is running.
- R11: Every chip select that is not asserted sits at the level of bit 4 (1 when bit 4 is set, 0 when it is clear), in both modes.
- R12: Bit 10 clears itself in the cycle after `xfer_done`. While a burst runs, control writes are ignored and the control word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Current control word |
| burst_len | input | CNT_W | Total bytes to clock, taken at start |
| tx_len | input | CNT_W | Bytes to take from the transmit FIFO, taken at start |
| tx_valid | input | 1 | Transmit FIFO is not empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Take the head byte this cycle |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | 8 | Received byte |
| sclk_en | input | 1 | Half-period tick from the clock divider |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | NCS | Chip-select pins |
| xfer_done | output | 1 | One-cycle burst-complete pulse |

## Verification
Two things can fall in one cycle: the final SCLK edge of a byte and the hand-off of that byte to the receive FIFO. In phase-1 mode the eighth sample is taken on that same closing edge, so the pushed byte must already hold the bit sampled in that cycle. This is provoked with phase 1 and `sclk_en` high on every cycle, against a pseudo-random MISO stream. A reference model in the bench predicts `rx_data` in each push cycle and the bench compares the two. A second collision is a control write that lands on a running burst or its completion cycle. It is judged by comparing the control word and the following idle SCLK level against the model.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int CTRL_W   = 32;
    localparam int SEL_W    = 2;

    localparam int B_EN     = 0;
    localparam int B_HOST   = 1;
    localparam int B_CPHA   = 2;
    localparam int B_CPOL   = 3;
    localparam int B_CSLOW  = 4;
    localparam int B_LSB    = 6;
    localparam int B_GO     = 10;
    localparam int B_SEL    = 12;
    localparam int B_DROP   = 15;
    localparam int B_MAN    = 16;
    localparam int B_MANLVL = 17;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_FIN   = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             cs_low;
        logic             lsb;
        logic             drop;
        logic             manual;
        logic             man_lvl;
        logic [SEL_W-1:0] sel;
    } mode_t;

    function automatic mode_t decode_mode(input logic [CTRL_W-1:0] r);
        mode_t m;
        m.cpha    = r[B_CPHA];
        m.cpol    = r[B_CPOL];
        m.cs_low  = r[B_CSLOW];
        m.lsb     = r[B_LSB];
        m.drop    = r[B_DROP];
        m.manual  = r[B_MAN];
        m.man_lvl = r[B_MANLVL];
        m.sel     = r[B_SEL +: SEL_W];
        return m;
    endfunction

    function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b,
                                            input logic lsb);
        return lsb ? {b, cur[7:1]} : {cur[6:0], b};
    endfunction

    function automatic logic [7:0] shift_out(input logic [7:0] cur, input logic lsb);
        return lsb ? {1'b0, cur[7:1]} : {cur[6:0], 1'b0};
    endfunction

endpackage

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] burst_in,
    input  logic [CNT_W-1:0] tx_in,
    input  logic             tx_valid,
    input  logic             byte_end,
    output eng_state_t       state,
    output logic             tx_take,
    output logic             fill_zero
);

    logic [CNT_W-1:0] rem_burst;
    logic [CNT_W-1:0] rem_tx;
    logic             have_bytes;
    logic             owe_tx;

    assign have_bytes = (rem_burst != '0);
    assign owe_tx     = (rem_tx != '0);
    assign tx_take    = (state == ST_LOAD) && have_bytes && owe_tx && tx_valid;
    assign fill_zero  = (state == ST_LOAD) && have_bytes && !owe_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rem_burst <= '0;
            rem_tx    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        rem_burst <= burst_in;
                        rem_tx    <= tx_in;
                        state     <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (!have_bytes) begin
                        state <= ST_FIN;
                    end else if (tx_take) begin
                        rem_tx <= rem_tx - 1'b1;
                        state  <= ST_SHIFT;
                    end else if (fill_zero) begin
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (byte_end) begin
                        rem_burst <= rem_burst - 1'b1;
                        state     <= ST_LOAD;
                    end
                end
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
    import spi_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       active,
    input  logic       tick,
    input  logic       lsb,
    input  logic       cpha,
    input  logic       cpol,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_end,
    output logic [7:0] rx_word
);

    logic [7:0] tx_sr;
    logic [7:0] rx_sr;
    logic [3:0] edge_cnt;
    logic       step;
    logic       leading;
    logic       sample_now;
    logic       change_now;
    logic [7:0] rx_next;

    assign step       = active && tick;
    assign leading    = !edge_cnt[0];
    assign sample_now = step && (leading ^ cpha);
    assign change_now = step && !(leading ^ cpha) && !(cpha && edge_cnt == 4'd0);
    assign rx_next    = shift_in(rx_sr, miso, lsb);

    assign rx_word  = sample_now ? rx_next : rx_sr;
    assign byte_end = step && (edge_cnt == 4'd15);
    assign sclk     = cpol ^ edge_cnt[0];
    assign mosi     = active ? (lsb ? tx_sr[0] : tx_sr[7]) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr    <= '0;
            rx_sr    <= '0;
            edge_cnt <= '0;
        end else if (load) begin
            tx_sr    <= load_byte;
            rx_sr    <= '0;
            edge_cnt <= '0;
        end else if (step) begin
            edge_cnt <= edge_cnt + 4'd1;
            if (sample_now) rx_sr <= rx_next;
            if (change_now) tx_sr <= shift_out(tx_sr, lsb);
        end
    end

endmodule

// File: rtl/spi_eng_csdrv.sv
module spi_eng_csdrv
    import spi_eng_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             active_low,
    input  logic             manual,
    input  logic             man_level,
    input  logic             engaged,
    output logic [NCS-1:0]   cs_o
);

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_o[i] = (sel == SEL_W'(i))
                       ? (manual ? man_level : (engaged ? ~active_low : active_low))
                       : active_low;
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int NCS   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wdata,
    output logic [31:0]      ctrl_q,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] tx_len,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [7:0]       rx_data,
    input  logic             sclk_en,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic [NCS-1:0]   cs_o,
    output logic             xfer_done
);

    logic [CTRL_W-1:0] ctrl_r;
    logic [CTRL_W-1:0] ctrl_next;
    mode_t             mode;
    eng_state_t        state;
    logic              busy;
    logic              launch;
    logic              tx_take;
    logic              fill_zero;
    logic              byte_end;
    logic [7:0]        rx_word;

    assign busy   = ctrl_r[B_GO];
    assign launch = ctrl_we && !busy && ctrl_wdata[B_GO]
                  && ctrl_wdata[B_EN] && ctrl_wdata[B_HOST];
    assign mode   = decode_mode(ctrl_r);

    always_comb begin
        ctrl_next       = ctrl_wdata;
        ctrl_next[B_GO] = launch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
        end else if (state == ST_FIN) begin
            ctrl_r[B_GO] <= 1'b0;
        end else if (ctrl_we && !busy) begin
            ctrl_r <= ctrl_next;
        end
    end

    spi_eng_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .burst_in  (burst_len),
        .tx_in     (tx_len),
        .tx_valid  (tx_valid),
        .byte_end  (byte_end),
        .state     (state),
        .tx_take   (tx_take),
        .fill_zero (fill_zero)
    );

    spi_eng_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_take || fill_zero),
        .load_byte (tx_take ? tx_data : 8'h00),
        .active    (state == ST_SHIFT),
        .tick      (sclk_en),
        .lsb       (mode.lsb),
        .cpha      (mode.cpha),
        .cpol      (mode.cpol),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_end  (byte_end),
        .rx_word   (rx_word)
    );

    spi_eng_csdrv #(.NCS(NCS)) u_cs (
        .sel        (mode.sel),
        .active_low (mode.cs_low),
        .manual     (mode.manual),
        .man_level  (mode.man_lvl),
        .engaged    (state == ST_LOAD || state == ST_SHIFT),
        .cs_o       (cs_o)
    );

    assign ctrl_q    = ctrl_r;
    assign tx_pop    = tx_take;
    assign rx_push   = byte_end && !mode.drop;
    assign rx_data   = rx_word;
    assign xfer_done = (state == ST_FIN);

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           ctrl_we,
    input logic [31:0]    ctrl_q,
    input logic           tx_pop,
    input logic           tx_valid,
    input logic           rx_push,
    input logic           sclk,
    input logic           sclk_en,
    input logic [NCS-1:0] cs_o,
    input logic           xfer_done
);

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> tx_valid); // R7

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[10] |-> (sclk == ctrl_q[3])); // R4

    AST_SCLK_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (!sclk_en && !ctrl_we) |=> $stable(sclk)); // R8

    AST_DROP_SILENCES_RX: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !ctrl_q[15]); // R6

    AST_GO_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !ctrl_q[10]); // R12

    AST_CTRL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[10] && !xfer_done) |=> $stable(ctrl_q)); // R12

    AST_ONE_CS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $countones(cs_o ^ {NCS{ctrl_q[4]}}) <= 1); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done); // R2

endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .ctrl_q    (ctrl_q),
    .tx_pop    (tx_pop),
    .tx_valid  (tx_valid),
    .rx_push   (rx_push),
    .sclk      (sclk),
    .sclk_en   (sclk_en),
    .cs_o      (cs_o),
    .xfer_done (xfer_done)
);

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/1ps
module tb_spi_xfer_engine;

    localparam logic [31:0] C_EN    = 32'h1;
    localparam logic [31:0] C_HOST  = 32'h2;
    localparam logic [31:0] C_CPHA  = 32'h4;
    localparam logic [31:0] C_CPOL  = 32'h8;
    localparam logic [31:0] C_CSLOW = 32'h10;
    localparam logic [31:0] C_LSB   = 32'h40;
    localparam logic [31:0] C_GO    = 32'h400;
    localparam logic [31:0] C_DROP  = 32'h8000;
    localparam logic [31:0] C_MAN   = 32'h10000;
    localparam logic [31:0] C_LVL   = 32'h20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_q;
    logic [23:0] burst_len = '0;
    logic [23:0] tx_len = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_pop;
    logic        rx_push;
    logic [7:0]  rx_data;
    logic        sclk_en = 1'b0;
    logic        miso = 1'b0;
    logic        sclk;
    logic        mosi;
    logic [3:0]  cs_o;
    logic        xfer_done;

    always #2.5 clk = ~clk;

    spi_xfer_engine dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .burst_len(burst_len), .tx_len(tx_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sclk_en(sclk_en), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_o(cs_o), .xfer_done(xfer_done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  txq[$];
    bit          pop_pend = 0;
    bit          hold_tx = 0;
    int          sclk_div = 1;
    int          divcnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    int          n_pop, n_push, n_done, n_edge;
    logic        last_sclk = 1'b0;

    // reference model state
    int          m_st = 0;
    logic [31:0] m_ctrl = '0;
    int          m_rb = 0;
    int          m_rt = 0;
    logic [7:0]  m_sh = '0;
    logic [7:0]  m_rx = '0;
    int          m_h = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit lead, samp, acc, cpha, lsb;
        logic [7:0] rxn;
        if (rst) begin
            m_st = 0; m_ctrl = '0; m_rb = 0; m_rt = 0; m_sh = '0; m_rx = '0; m_h = 0;
            return;
        end
        cpha = m_ctrl[2];
        lsb  = m_ctrl[6];
        case (m_st)
            0: if (ctrl_we) begin
                acc = ctrl_wdata[10] && ctrl_wdata[0] && ctrl_wdata[1];
                m_ctrl = ctrl_wdata;
                m_ctrl[10] = acc;
                if (acc) begin
                    m_rb = int'(burst_len); m_rt = int'(tx_len); m_st = 1;
                end
            end
            1: begin
                if (m_rb == 0) m_st = 3;
                else if (m_rt != 0) begin
                    if (tx_valid) begin
                        m_sh = tx_data; m_rt--; m_rx = '0; m_h = 0; m_st = 2;
                    end
                end else begin
                    m_sh = 8'h00; m_rx = '0; m_h = 0; m_st = 2;
                end
            end
            2: if (sclk_en) begin
                lead = (m_h % 2) == 0;
                samp = lead ^ cpha;
                rxn  = lsb ? {miso, m_rx[7:1]} : {m_rx[6:0], miso};
                if (samp) m_rx = rxn;
                if (!samp && !(cpha && m_h == 0))
                    m_sh = lsb ? {1'b0, m_sh[7:1]} : {m_sh[6:0], 1'b0};
                if (m_h == 15) begin
                    m_h = 0; m_rb--; m_st = 1;
                end else m_h++;
            end
            default: begin
                m_ctrl[10] = 1'b0; m_st = 0;
            end
        endcase
    endtask

    always @(posedge clk) model_step();

    task automatic compare_all();
        bit         cpol, cpha, lsb, lead, samp;
        logic       e_sclk, e_mosi, e_pop, e_push, e_done;
        logic [7:0] rxn, e_rxd;
        logic [3:0] e_cs;
        int         sel;
        cpol = m_ctrl[3]; cpha = m_ctrl[2]; lsb = m_ctrl[6];
        e_sclk = cpol ^ ((m_h % 2) == 1);
        e_mosi = (m_st == 2) ? (lsb ? m_sh[0] : m_sh[7]) : 1'b0;
        e_pop  = (m_st == 1) && (m_rb != 0) && (m_rt != 0) && tx_valid;
        lead   = (m_h % 2) == 0;
        samp   = (m_st == 2) && sclk_en && (lead ^ cpha);
        rxn    = lsb ? {miso, m_rx[7:1]} : {m_rx[6:0], miso};
        e_rxd  = samp ? rxn : m_rx;
        e_push = (m_st == 2) && sclk_en && (m_h == 15) && !m_ctrl[15];
        e_done = (m_st == 3);
        sel    = int'(m_ctrl[13:12]);
        for (int i = 0; i < 4; i++) begin
            if (i != sel) e_cs[i] = m_ctrl[4];
            else if (m_ctrl[16]) e_cs[i] = m_ctrl[17];
            else e_cs[i] = (m_st == 1 || m_st == 2) ? ~m_ctrl[4] : m_ctrl[4];
        end
        chk(sclk === e_sclk, "R4 R8", "sclk", {31'd0, sclk}, {31'd0, e_sclk});
        chk(mosi === e_mosi, "R5", "mosi", {31'd0, mosi}, {31'd0, e_mosi});
        chk(tx_pop === e_pop, "R3 R7", "tx_pop", {31'd0, tx_pop}, {31'd0, e_pop});
        chk(rx_push === e_push, "R6", "rx_push", {31'd0, rx_push}, {31'd0, e_push});
        if (e_push)
            chk(rx_data === e_rxd, "R5", "rx_data", {24'd0, rx_data}, {24'd0, e_rxd});
        chk(xfer_done === e_done, "R2", "xfer_done", {31'd0, xfer_done}, {31'd0, e_done});
        chk(cs_o === e_cs, "R9 R10 R11", "cs_o", {28'd0, cs_o}, {28'd0, e_cs});
        chk(ctrl_q === m_ctrl, "R12", "ctrl_q", ctrl_q, m_ctrl);
    endtask

    task automatic cycle();
        logic [7:0] dropped;
        @(negedge clk);
        if (pop_pend && txq.size() > 0) dropped = txq.pop_front();
        pop_pend = 0;
        tx_valid = (txq.size() > 0) && !hold_tx;
        tx_data  = (txq.size() > 0) ? txq[0] : 8'h00;
        divcnt++;
        sclk_en  = (divcnt % sclk_div) == 0;
        lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso     = lfsr[0];
        #1;
        if (!rst) begin
            compare_all();
            pop_pend = tx_pop;
            if (tx_pop) n_pop++;
            if (rx_push) n_push++;
            if (xfer_done) n_done++;
            if (ctrl_q[10] && sclk !== last_sclk) n_edge++;
        end
        last_sclk = sclk;
    endtask

    task automatic write_ctrl(input logic [31:0] w);
        ctrl_wdata = w; ctrl_we = 1'b1;
        cycle();
        ctrl_we = 1'b0;
    endtask

    task automatic run_burst(input logic [31:0] cw, input int bl, input int tl,
                             input int nq, input int div, input int hold_cyc);
        int guard, want_pop, left;
        for (int i = 0; i < nq; i++) txq.push_back(8'(i * 37 + bl * 11 + 5));
        sclk_div = div;
        burst_len = 24'(bl); tx_len = 24'(tl);
        write_ctrl(cw & ~C_GO);
        cycle();
        n_pop = 0; n_push = 0; n_done = 0; n_edge = 0;
        hold_tx = (hold_cyc > 0);
        write_ctrl(cw);
        if (hold_cyc > 0) begin
            for (int i = 0; i < hold_cyc; i++) cycle();
            chk(n_edge == 0, "R7", "edges during stall", n_edge, 0);
            chk(n_pop == 0, "R7", "pops during stall", n_pop, 0);
            hold_tx = 0;
        end
        guard = 0;
        while (n_done == 0 && guard < 20000) begin
            cycle(); guard++;
        end
        chk(guard < 20000, "R2", "watchdog", guard, 20000);
        cycle(); cycle();
        want_pop = (tl < bl) ? tl : bl;
        left = nq - want_pop;
        if (left < 0) left = 0;
        chk(n_edge == 16 * bl, "R2", "sclk edge count", n_edge, 16 * bl);
        chk(n_done == 1, "R2", "done pulses", n_done, 1);
        chk(n_pop == want_pop, "R3", "pop count", n_pop, want_pop);
        chk(txq.size() == left, "R3", "fifo leftover", txq.size(), left);
        if ((cw & C_DROP) != 0)
            chk(n_push == 0, "R6", "push count", n_push, 0);
        else
            chk(n_push == bl, "R6", "push count", n_push, bl);
        chk(ctrl_q[10] == 1'b0, "R12", "start bit after done", {31'd0, ctrl_q[10]}, 0);
        txq.delete();
    endtask

    initial begin
        logic [31:0] snap;
        int guard;
        n_pop = 0; n_push = 0; n_done = 0; n_edge = 0;
        for (int i = 0; i < 3; i++) cycle();
        rst = 1'b0;
        cycle();
        chk(ctrl_q == 32'd0, "R1", "reset ctrl_q", ctrl_q, 0);
        chk(cs_o == 4'b0000, "R11", "reset cs_o", {28'd0, cs_o}, 0);
        chk(sclk == 1'b0 && mosi == 1'b0, "R4", "reset sclk/mosi", {30'd0, sclk, mosi}, 0);
        chk(xfer_done == 1'b0, "R2", "reset done", {31'd0, xfer_done}, 0);

        // R1: start without enable is not kept
        write_ctrl(C_HOST | C_GO | C_CSLOW);
        for (int i = 0; i < 4; i++) cycle();
        chk(ctrl_q == (C_HOST | C_CSLOW), "R1", "start without enable", ctrl_q, C_HOST | C_CSLOW);
        chk(cs_o == 4'b1111, "R11", "idle high cs", {28'd0, cs_o}, 32'hF);

        // R2 R4 R5 R9: mode 0, MSB first, fast ticks
        run_burst(C_EN | C_HOST | C_CSLOW | C_GO, 3, 3, 3, 1, 0);
        // R4 R5 R8: mode 3, LSB first, slow ticks, zero fill
        run_burst(C_EN | C_HOST | C_CSLOW | C_CPOL | C_CPHA | C_LSB | (32'd1 << 12) | C_GO, 4, 2, 2, 2, 0);
        // R3: transmit count beyond burst count
        run_burst(C_EN | C_HOST | C_CPHA | (32'd2 << 12) | C_GO, 2, 5, 5, 3, 0);
        // R6: drop received bytes
        run_burst(C_EN | C_HOST | C_CSLOW | C_CPOL | C_DROP | C_GO, 3, 3, 3, 1, 0);
        // R7: stall with empty FIFO
        run_burst(C_EN | C_HOST | C_CSLOW | C_GO, 2, 2, 2, 1, 20);
        // R2: zero-length burst
        run_burst(C_EN | C_HOST | C_CSLOW | C_GO, 0, 0, 0, 1, 0);
        // R9 R11: active-high auto select on index 3, phase-1 push collision
        run_burst(C_EN | C_HOST | C_CPHA | (32'd3 << 12) | C_GO, 3, 1, 1, 1, 0);

        // R10 R11: manual chip select
        write_ctrl(C_EN | C_HOST | C_CSLOW | C_MAN | (32'd2 << 12));
        cycle();
        chk(cs_o == 4'b1011, "R10", "manual level low", {28'd0, cs_o}, 32'hB);
        write_ctrl(C_EN | C_HOST | C_MAN | C_LVL | (32'd1 << 12));
        cycle();
        chk(cs_o == 4'b0010, "R10", "manual level high", {28'd0, cs_o}, 32'h2);
        run_burst(C_EN | C_HOST | C_CSLOW | C_MAN | (32'd2 << 12) | C_GO, 2, 2, 2, 1, 0);

        // R12: writes during a burst are ignored
        txq.push_back(8'h5A); txq.push_back(8'hC3);
        sclk_div = 1; burst_len = 24'd2; tx_len = 24'd2;
        write_ctrl(C_EN | C_HOST | C_CSLOW);
        n_done = 0;
        write_ctrl(C_EN | C_HOST | C_CSLOW | C_GO);
        for (int i = 0; i < 5; i++) cycle();
        snap = ctrl_q;
        write_ctrl(C_EN | C_HOST | C_CPOL | C_LSB | C_GO);
        cycle();
        chk(ctrl_q == snap, "R12", "ctrl write while busy", ctrl_q, snap);
        guard = 0;
        while (n_done == 0 && guard < 20000) begin
            cycle(); guard++;
        end
        chk(guard < 20000, "R12", "watchdog", guard, 20000);
        cycle();
        chk(ctrl_q == (C_EN | C_HOST | C_CSLOW), "R12", "ctrl after busy write", ctrl_q,
            C_EN | C_HOST | C_CSLOW);
        txq.delete();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule